// File: doc/BRIEF.md
# Predicated Writeback Stage with Deferred Fault Tags

This block is the final stage of an explicitly parallel integer core. It holds the predicate bank, 64 one-bit flags that decide whether an operation may change state, and the general register file. Each general register has a deferred-fault tag beside it. Every operation arriving at the stage names a guarding predicate. If that predicate is false, the operation leaves every register, tag and output untouched. If it is true, the stage commits the operation.

When a result is committed, the stage stores the data together with a tag. The tag is the OR of the tags on the sources the operation uses. A speculative operation that hit a fault sets the tag on its destination instead of trapping. A non-speculative operation that hit a fault raises a fault pulse and writes nothing. A check operation asks for a branch to recovery code when the register it names carries a set tag.

Only compare operations write predicates. There are three kinds: a plain compare, a predicate clear, and an OR-style compare that can only set its target. Clearing the target first and then issuing several OR-style compares combines their conditions into one flag that a later branch can use. Two observation read ports bring the register and predicate state out for the surrounding pipeline.

Top module: `pwb_writeback`

## Requirements
- R1: After reset every general register reads data 0 with tag 0, predicate 0 reads 1, every other predicate reads 0, and `fault` and `recover` are 0.
- R2: An operation whose guarding predicate (`qp_idx`) reads 0 changes no register, tag or predicate, and raises neither `fault` nor `recover` in the following cycle.
- R3: Predicate 0 always reads 1. A compare, clear or OR-compare aimed at predicate 0 leaves it at 1.
- R4: A committed write (`op_kind` = 1) of a non-faulting operation stores `result` at `dst_idx`. The observation port shows it from the cycle after the clock edge on which it was applied.
- R5: The tag stored by a committed write is the OR of the tags of the sources whose `src_a_used` / `src_b_used` is 1, ORed with `exc_flag AND spec_flag`. An unused source contributes nothing.
- R6: A committed write with `exc_flag`=1 and `spec_flag`=1 stores its data with tag 1 and does not raise `fault`.
- R7: A committed write with `exc_flag`=1 and `spec_flag`=0 raises `fault` for exactly the next cycle and leaves the destination register and its tag unchanged.
- R8: A committed check (`op_kind` = 5) raises `recover` in the next cycle exactly when the tag of register `src_a_idx` is 1.
- R9: A committed compare (`op_kind` = 2) writes `cmp_true` into predicate `pdst_idx`.
- R10: A committed clear (`op_kind` = 4) writes 0 into predicate `pdst_idx`. A committed OR-compare (`op_kind` = 3) writes 1 when `cmp_true` is 1 and leaves the predicate unchanged otherwise, so several OR-compares accumulate. `op_kind` 0 is idle.
- R11: Register, tag and predicate writes take effect at the clock edge. A read in the same cycle as the write returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is present this cycle |
| op_kind | input | 3 | 0 idle, 1 write, 2 compare, 3 OR-compare, 4 predicate clear, 5 check |
| qp_idx | input | 6 | Guarding predicate index |
| src_a_idx | input | 5 | First source register (also the register a check tests) |
| src_a_used | input | 1 | First source feeds the result |
| src_b_idx | input | 5 | Second source register |
| src_b_used | input | 1 | Second source feeds the result |
| dst_idx | input | 5 | Destination general register |
| pdst_idx | input | 6 | Destination predicate for compare kinds |
| cmp_true | input | 1 | Outcome of the comparison |
| result | input | 64 | Result value to store |
| exc_flag | input | 1 | The operation hit a fault |
| spec_flag | input | 1 | The operation was issued speculatively |
| fault | output | 1 | Non-deferred fault raised by the previous operation |
| recover | output | 1 | Branch-to-recovery request from the previous check |
| obs_reg_idx | input | 5 | Register observation index |
| obs_reg_data | output | 64 | Data of the observed register |
| obs_reg_tag | output | 1 | Tag of the observed register |
| obs_pred_idx | input | 6 | Predicate observation index |
| obs_pred_val | output | 1 | Value of the observed predicate |

## Verification
Writes are tried in several forms: with no sources, with two tagged and untagged sources, with one tagged source present but marked unused, and with each combination of fault and speculation. These separate tag propagation, deferral and the raising of a fault. Checks are applied to a tagged register, to an untagged register, and under a false guard, which shows that recovery depends on both the tag and the guard. A predicate is taken through a clear followed by false, true and false OR-compares, which shows that the result accumulates and is not simply overwritten. Same-cycle reads of a register and of a predicate show the old value before the edge and the new one after it.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,
        OP_WRITE = 3'd1,
        OP_CMP   = 3'd2,
        OP_CMPOR = 3'd3,
        OP_PCLR  = 3'd4,
        OP_CHECK = 3'd5
    } op_kind_e;
endpackage

// File: rtl/pwb_decode.sv
// Pure combinational decision logic: gating, tag merge, predicate update.
module pwb_decode
    import pwb_pkg::*;
(
    input  logic     op_valid,
    input  op_kind_e kind,
    input  logic     qp_val,
    input  logic     tag_a,
    input  logic     tag_b,
    input  logic     use_a,
    input  logic     use_b,
    input  logic     exc_flag,
    input  logic     spec_flag,
    input  logic     cmp_true,
    output logic     qp_ok,
    output logic     reg_we,
    output logic     reg_tag,
    output logic     pred_we,
    output logic     pred_val,
    output logic     fault_d,
    output logic     recover_d
);
    logic inherited;
    logic hard_fault;

    always_comb begin
        qp_ok      = op_valid && qp_val;
        inherited  = (use_a && tag_a) || (use_b && tag_b);
        hard_fault = exc_flag && !spec_flag;
        reg_we     = 1'b0;
        reg_tag    = 1'b0;
        pred_we    = 1'b0;
        pred_val   = 1'b0;
        fault_d    = 1'b0;
        recover_d  = 1'b0;
        if (qp_ok) begin
            unique case (kind)
                OP_WRITE: begin
                    fault_d = hard_fault;
                    reg_we  = !hard_fault;
                    reg_tag = inherited || (exc_flag && spec_flag);
                end
                OP_CMP: begin
                    pred_we  = 1'b1;
                    pred_val = cmp_true;
                end
                OP_CMPOR: begin
                    pred_we  = cmp_true;
                    pred_val = 1'b1;
                end
                OP_PCLR: begin
                    pred_we  = 1'b1;
                    pred_val = 1'b0;
                end
                OP_CHECK: begin
                    recover_d = tag_a;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pwb_pred_bank.sv
// One-bit predicate bank; entry 0 is held at 1.
module pwb_pred_bank #(
    parameter int NUM_PRED = 64,
    localparam int IDX_W = $clog2(NUM_PRED)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic             wval,
    input  logic [IDX_W-1:0] qidx,
    output logic             qval,
    input  logic [IDX_W-1:0] oidx,
    output logic             oval
);
    typedef struct packed {
        logic [NUM_PRED-1:0] bits;
    } pred_state_t;

    localparam logic [NUM_PRED-1:0] RESET_BITS = {{(NUM_PRED-1){1'b0}}, 1'b1};

    pred_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we && (widx != '0)) begin
            st_d.bits[widx] = wval;
        end
        st_d.bits[0] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.bits <= RESET_BITS;
        end else begin
            st_q <= st_d;
        end
    end

    assign qval = st_q.bits[qidx];
    assign oval = st_q.bits[oidx];
endmodule

// File: rtl/pwb_reg_file.sv
// General register data with a deferred-fault tag per entry.
module pwb_reg_file #(
    parameter int NUM_REG = 32,
    parameter int DATA_W  = 64,
    localparam int IDX_W = $clog2(NUM_REG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wtag,
    input  logic [IDX_W-1:0]  aidx,
    output logic              atag,
    input  logic [IDX_W-1:0]  bidx,
    output logic              btag,
    input  logic [IDX_W-1:0]  oidx,
    output logic [DATA_W-1:0] odata,
    output logic              otag
);
    typedef struct packed {
        logic [NUM_REG-1:0][DATA_W-1:0] data;
        logic [NUM_REG-1:0]             tag;
    } rf_state_t;

    rf_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.data[widx] = wdata;
            st_d.tag[widx]  = wtag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign atag  = st_q.tag[aidx];
    assign btag  = st_q.tag[bidx];
    assign odata = st_q.data[oidx];
    assign otag  = st_q.tag[oidx];
endmodule

// File: rtl/pwb_writeback.sv
module pwb_writeback
    import pwb_pkg::*;
#(
    parameter int NUM_PRED = 64,
    parameter int NUM_REG  = 32,
    parameter int DATA_W   = 64,
    localparam int PIDX_W = $clog2(NUM_PRED),
    localparam int RIDX_W = $clog2(NUM_REG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_kind,
    input  logic [PIDX_W-1:0] qp_idx,
    input  logic [RIDX_W-1:0] src_a_idx,
    input  logic              src_a_used,
    input  logic [RIDX_W-1:0] src_b_idx,
    input  logic              src_b_used,
    input  logic [RIDX_W-1:0] dst_idx,
    input  logic [PIDX_W-1:0] pdst_idx,
    input  logic              cmp_true,
    input  logic [DATA_W-1:0] result,
    input  logic              exc_flag,
    input  logic              spec_flag,
    output logic              fault,
    output logic              recover,
    input  logic [RIDX_W-1:0] obs_reg_idx,
    output logic [DATA_W-1:0] obs_reg_data,
    output logic              obs_reg_tag,
    input  logic [PIDX_W-1:0] obs_pred_idx,
    output logic              obs_pred_val
);
    typedef struct packed {
        logic fault;
        logic recover;
    } out_state_t;

    out_state_t out_d, out_q;

    logic qp_val, src_a_tag, src_b_tag;
    logic qp_ok, reg_we, reg_tag, pred_we, pred_val, fault_d, recover_d;

    pwb_pred_bank #(.NUM_PRED(NUM_PRED)) u_pred (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (pred_we),
        .widx (pdst_idx),
        .wval (pred_val),
        .qidx (qp_idx),
        .qval (qp_val),
        .oidx (obs_pred_idx),
        .oval (obs_pred_val)
    );

    pwb_reg_file #(.NUM_REG(NUM_REG), .DATA_W(DATA_W)) u_rf (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (reg_we),
        .widx (dst_idx),
        .wdata(result),
        .wtag (reg_tag),
        .aidx (src_a_idx),
        .atag (src_a_tag),
        .bidx (src_b_idx),
        .btag (src_b_tag),
        .oidx (obs_reg_idx),
        .odata(obs_reg_data),
        .otag (obs_reg_tag)
    );

    pwb_decode u_dec (
        .op_valid (op_valid),
        .kind     (op_kind_e'(op_kind)),
        .qp_val   (qp_val),
        .tag_a    (src_a_tag),
        .tag_b    (src_b_tag),
        .use_a    (src_a_used),
        .use_b    (src_b_used),
        .exc_flag (exc_flag),
        .spec_flag(spec_flag),
        .cmp_true (cmp_true),
        .qp_ok    (qp_ok),
        .reg_we   (reg_we),
        .reg_tag  (reg_tag),
        .pred_we  (pred_we),
        .pred_val (pred_val),
        .fault_d  (fault_d),
        .recover_d(recover_d)
    );

    always_comb begin
        out_d.fault   = fault_d;
        out_d.recover = recover_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign fault   = out_q.fault;
    assign recover = out_q.recover;
endmodule

// File: rtl/pwb_writeback_chk.sv
module pwb_writeback_chk
    import pwb_pkg::*;
#(
    parameter int PIDX_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [2:0]        op_kind,
    input logic              exc_flag,
    input logic              spec_flag,
    input logic              qp_ok,
    input logic              src_a_tag,
    input logic              fault,
    input logic              recover,
    input logic [PIDX_W-1:0] obs_pred_idx,
    input logic              obs_pred_val
);
    // R7
    fault_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> $past(qp_ok && op_kind == OP_WRITE && exc_flag && !spec_flag));

    // R6
    spec_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (qp_ok && op_kind == OP_WRITE && spec_flag) |=> !fault);

    // R8
    recover_when_tagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (qp_ok && op_kind == OP_CHECK && src_a_tag) |=> recover);

    // R8
    recover_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        recover |-> $past(qp_ok && op_kind == OP_CHECK && src_a_tag));

    // R2
    gated_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !qp_ok) |=> (!fault && !recover));

    // R3
    pred_zero_true_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (obs_pred_idx == '0) |-> obs_pred_val);
endmodule

bind pwb_writeback pwb_writeback_chk #(.PIDX_W(PIDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_valid    (op_valid),
    .op_kind     (op_kind),
    .exc_flag    (exc_flag),
    .spec_flag   (spec_flag),
    .qp_ok       (qp_ok),
    .src_a_tag   (src_a_tag),
    .fault       (fault),
    .recover     (recover),
    .obs_pred_idx(obs_pred_idx),
    .obs_pred_val(obs_pred_val)
);

// File: tb/tb_pwb_writeback.sv
`timescale 1ns/1ps
module tb_pwb_writeback;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_kind = 3'd0;
    logic [5:0]  qp_idx = '0;
    logic [4:0]  src_a_idx = '0;
    logic        src_a_used = 1'b0;
    logic [4:0]  src_b_idx = '0;
    logic        src_b_used = 1'b0;
    logic [4:0]  dst_idx = '0;
    logic [5:0]  pdst_idx = '0;
    logic        cmp_true = 1'b0;
    logic [63:0] result = '0;
    logic        exc_flag = 1'b0;
    logic        spec_flag = 1'b0;
    logic        fault, recover;
    logic [4:0]  obs_reg_idx = '0;
    logic [63:0] obs_reg_data;
    logic        obs_reg_tag;
    logic [5:0]  obs_pred_idx = '0;
    logic        obs_pred_val;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    pwb_writeback dut (.*);

    typedef struct packed {
        logic [7:0]  req;
        logic [2:0]  kind;
        logic [5:0]  qp;
        logic [4:0]  sa;
        logic        ua;
        logic [4:0]  sb;
        logic        ub;
        logic [4:0]  dst;
        logic [5:0]  pd;
        logic        cres;
        logic [63:0] data;
        logic        exc;
        logic        spec;
        logic        e_fault;
        logic        e_rec;
        logic [4:0]  rdi;
        logic [63:0] e_data;
        logic        e_tag;
        logic [5:0]  pri;
        logic        e_pr;
    } vec_t;

    localparam int NV = 17;
    // kind: 1 write, 2 compare, 3 OR-compare, 4 clear, 5 check
    localparam vec_t VECS [NV] = '{
        // R9 compare sets p5
        '{8'd9, 3'd2, 6'd0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 6'd5, 1'b1, 64'h0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd1, 64'h0, 1'b0, 6'd5, 1'b1},
        // R4 plain write under p5
        '{8'd4, 3'd1, 6'd5, 5'd0, 1'b0, 5'd0, 1'b0, 5'd1, 6'd0, 1'b0, 64'h11, 1'b0, 1'b0, 1'b0, 1'b0, 5'd1, 64'h11, 1'b0, 6'd5, 1'b1},
        // R2 false guard p6, faulting write ignored
        '{8'd2, 3'd1, 6'd6, 5'd0, 1'b0, 5'd0, 1'b0, 5'd2, 6'd0, 1'b0, 64'h22, 1'b1, 1'b0, 1'b0, 1'b0, 5'd2, 64'h0, 1'b0, 6'd6, 1'b0},
        // R6 speculative fault deferred into tag
        '{8'd6, 3'd1, 6'd0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd3, 6'd0, 1'b0, 64'h33, 1'b1, 1'b1, 1'b0, 1'b0, 5'd3, 64'h33, 1'b1, 6'd0, 1'b1},
        // R5 tagged r3 and clean r1 -> tag 1
        '{8'd5, 3'd1, 6'd0, 5'd3, 1'b1, 5'd1, 1'b1, 5'd4, 6'd0, 1'b0, 64'h44, 1'b0, 1'b0, 1'b0, 1'b0, 5'd4, 64'h44, 1'b1, 6'd0, 1'b1},
        // R5 tagged r3 present but unused -> tag 0
        '{8'd5, 3'd1, 6'd0, 5'd1, 1'b1, 5'd3, 1'b0, 5'd6, 6'd0, 1'b0, 64'h66, 1'b0, 1'b0, 1'b0, 1'b0, 5'd6, 64'h66, 1'b0, 6'd0, 1'b1},
        // R7 non-speculative fault: pulse, r7 untouched
        '{8'd7, 3'd1, 6'd0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd7, 6'd0, 1'b0, 64'h77, 1'b1, 1'b0, 1'b1, 1'b0, 5'd7, 64'h0, 1'b0, 6'd0, 1'b1},
        // R8 check tagged r4 -> recover
        '{8'd8, 3'd5, 6'd0, 5'd4, 1'b1, 5'd0, 1'b0, 5'd0, 6'd0, 1'b0, 64'h0, 1'b0, 1'b0, 1'b0, 1'b1, 5'd4, 64'h44, 1'b1, 6'd0, 1'b1},
        // R8 check clean r1 -> no recover
        '{8'd8, 3'd5, 6'd0, 5'd1, 1'b1, 5'd0, 1'b0, 5'd0, 6'd0, 1'b0, 64'h0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd1, 64'h11, 1'b0, 6'd0, 1'b1},
        // R2 check under false guard -> no recover
        '{8'd2, 3'd5, 6'd6, 5'd4, 1'b1, 5'd0, 1'b0, 5'd0, 6'd0, 1'b0, 64'h0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd4, 64'h44, 1'b1, 6'd0, 1'b1},
        // R10 clear p5
        '{8'd10, 3'd4, 6'd0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 6'd5, 1'b0, 64'h0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0, 64'h0, 1'b0, 6'd5, 1'b0},
        // R10 OR-compare false keeps 0
        '{8'd10, 3'd3, 6'd0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 6'd5, 1'b0, 64'h0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0, 64'h0, 1'b0, 6'd5, 1'b0},
        // R10 OR-compare true sets
        '{8'd10, 3'd3, 6'd0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 6'd5, 1'b1, 64'h0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0, 64'h0, 1'b0, 6'd5, 1'b1},
        // R10 OR-compare false keeps 1
        '{8'd10, 3'd3, 6'd0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 6'd5, 1'b0, 64'h0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0, 64'h0, 1'b0, 6'd5, 1'b1},
        // R3 compare false into p0 ignored
        '{8'd3, 3'd2, 6'd0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 6'd0, 1'b0, 64'h0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0, 64'h0, 1'b0, 6'd0, 1'b1},
        // R5 overwrite r4 from clean r1 clears tag
        '{8'd5, 3'd1, 6'd0, 5'd1, 1'b1, 5'd0, 1'b0, 5'd4, 6'd0, 1'b0, 64'h45, 1'b0, 1'b0, 1'b0, 1'b0, 5'd4, 64'h45, 1'b0, 6'd0, 1'b1},
        // R2 compare under false guard leaves p9
        '{8'd2, 3'd2, 6'd6, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 6'd9, 1'b1, 64'h0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0, 64'h0, 1'b0, 6'd9, 1'b0}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_op();
        op_valid = 1'b0; op_kind = 3'd0; qp_idx = '0;
        src_a_idx = '0; src_a_used = 1'b0; src_b_idx = '0; src_b_used = 1'b0;
        dst_idx = '0; pdst_idx = '0; cmp_true = 1'b0; result = '0;
        exc_flag = 1'b0; spec_flag = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        obs_reg_idx = 5'd1; obs_pred_idx = 6'd0;
        #1;
        chk("R1 data", obs_reg_data, 64'h0);
        chk("R1 tag", {63'h0, obs_reg_tag}, 64'h0);
        chk("R1 pred0", {63'h0, obs_pred_val}, 64'h1);
        chk("R1 fault", {63'h0, fault}, 64'h0);
        chk("R1 recover", {63'h0, recover}, 64'h0);
        obs_reg_idx = 5'd31; obs_pred_idx = 6'd63;
        #1;
        chk("R1 tag31", {63'h0, obs_reg_tag}, 64'h0);
        chk("R1 pred63", {63'h0, obs_pred_val}, 64'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            op_valid = 1'b1;
            op_kind = VECS[i].kind; qp_idx = VECS[i].qp;
            src_a_idx = VECS[i].sa; src_a_used = VECS[i].ua;
            src_b_idx = VECS[i].sb; src_b_used = VECS[i].ub;
            dst_idx = VECS[i].dst; pdst_idx = VECS[i].pd;
            cmp_true = VECS[i].cres; result = VECS[i].data;
            exc_flag = VECS[i].exc; spec_flag = VECS[i].spec;
            obs_reg_idx = VECS[i].rdi; obs_pred_idx = VECS[i].pri;
            @(posedge clk);
            #5;
            chk($sformatf("R%0d v%0d fault", VECS[i].req, i), {63'h0, fault}, {63'h0, VECS[i].e_fault});
            chk($sformatf("R%0d v%0d recover", VECS[i].req, i), {63'h0, recover}, {63'h0, VECS[i].e_rec});
            chk($sformatf("R%0d v%0d data", VECS[i].req, i), obs_reg_data, VECS[i].e_data);
            chk($sformatf("R%0d v%0d tag", VECS[i].req, i), {63'h0, obs_reg_tag}, {63'h0, VECS[i].e_tag});
            chk($sformatf("R%0d v%0d pred", VECS[i].req, i), {63'h0, obs_pred_val}, {63'h0, VECS[i].e_pr});
        end

        // R7 fault lasts one cycle only: idle op after the table
        @(negedge clk);
        clear_op();
        @(posedge clk);
        #5;
        chk("R7 fault idle", {63'h0, fault}, 64'h0);

        // R11 register write: old value before the edge, new after
        @(negedge clk);
        op_valid = 1'b1; op_kind = 3'd1; dst_idx = 5'd8; result = 64'h88;
        obs_reg_idx = 5'd8;
        #1;
        chk("R11 reg before edge", obs_reg_data, 64'h0);
        @(posedge clk);
        #5;
        chk("R11 reg after edge", obs_reg_data, 64'h88);

        // R11 predicate write: same timing
        @(negedge clk);
        clear_op();
        op_valid = 1'b1; op_kind = 3'd2; pdst_idx = 6'd9; cmp_true = 1'b1;
        obs_pred_idx = 6'd9;
        #1;
        chk("R11 pred before edge", {63'h0, obs_pred_val}, 64'h0);
        @(posedge clk);
        #5;
        chk("R11 pred after edge", {63'h0, obs_pred_val}, 64'h1);

        // R3 clear aimed at p0 ignored
        @(negedge clk);
        clear_op();
        op_valid = 1'b1; op_kind = 3'd4; pdst_idx = 6'd0; obs_pred_idx = 6'd0;
        @(posedge clk);
        #5;
        chk("R3 clear p0", {63'h0, obs_pred_val}, 64'h1);

        @(negedge clk);
        clear_op();
        @(posedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule